// File: doc/BRIEF.md
# Strobed Switch Channel Selector

This block turns a set of external selector switches into a frequency request for a synthesiser. Seven code lines pick one of 120 stored channels, and an active-low strobe tells the block when to act. Every input line is pulled up, so an open input reads as 1. The block passes the strobe and the code through two-flop synchronisers. It then finds a high-to-low transition of the strobe and requires the low level to persist for a programmable number of clock cycles before it believes the transition. Only then does it sample the code. A code inside the channel range reads a synchronous frequency table, and the stored word appears on the output together with a one-cycle valid pulse.

Once a strobe is accepted, a lockout window starts. While that window runs, any further falling edges are dropped; they are not queued. A code of 120 or above is treated as a wrong switch setting. It is discarded silently and does not start a lockout. Another block fills the table through a simple write port. The synthesiser itself sits outside this block.

The defaults assume a 50 MHz clock. `QUAL_CYCLES` = 28 gives a qualification time of 560 ns, and `LOCK_CYCLES` = 20000 gives a repeat interval of 400 µs. The response latency is a few cycles, far below the 350 µs allowed.

Top module: `chan_strobe_sel`

## Requirements
- R1: During reset and straight after it, `freq_vld_o` is 0 and `freq_o` is 0. Releasing reset while `set_ni` is high causes no capture.
- R2: If `set_ni` falls and stays low for at least `QUAL_CYCLES` clock samples, with `code_i` = c and c ≤ 119, the block raises `freq_vld_o` for exactly one cycle. In that cycle `freq_o` equals table entry c. Bit 0 of `code_i` is the least significant bit of the channel number.
- R3: A low level on `set_ni` that lasts `QUAL_CYCLES`−1 samples or fewer gives no valid pulse and starts no lockout. A low level of exactly `QUAL_CYCLES` samples is accepted.
- R4: A qualified strobe whose code is 120 to 127 gives no valid pulse, reads nothing from the table and starts no lockout.
- R5: An accepted in-range strobe starts a lockout of `LOCK_CYCLES` cycles. A falling edge whose first synchronised low sample lands inside the lockout is ignored for good. A falling edge after the lockout has ended is accepted.
- R6: If `set_ni` is held low past the lockout, the block captures only once. A new capture needs `set_ni` to return high and then fall again.
- R7: A write through `tbl_we_i`/`tbl_waddr_i`/`tbl_wdata_i` to an address of 119 or below replaces that entry. Every later selection of that channel returns the new word.
- R8: `freq_o` keeps its value in every cycle in which `freq_vld_o` is low.
- R9: The clock sample at which `set_ni` is first seen low is edge k. `freq_vld_o` is then high in the cycle after edge k+`QUAL_CYCLES`+2. This takes two synchroniser stages, `QUAL_CYCLES` samples of qualification, one table read and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_ni | input | 1 | Selection strobe from a switch, active low, asynchronous |
| code_i | input | CODE_W | Channel code from the switches, asynchronous |
| tbl_we_i | input | 1 | Table write enable |
| tbl_waddr_i | input | CODE_W | Table write address |
| tbl_wdata_i | input | FREQ_W | Table write data (frequency word) |
| freq_o | output | FREQ_W | Most recently selected frequency word |
| freq_vld_o | output | 1 | One-cycle pulse marking a newly selected frequency |

## Verification
The hardest state to reach from the ports is a falling edge that arrives while the lockout is still running. The stimulus has to be timed so that the edge does not simply return the block to an idle state from which a later edge could succeed. The bench first lands an accepted strobe. It then drops the strobe again partway through the window and holds it low well past qualification, and it checks that the output word does not change. Only after the window has fully expired does it send another falling edge, which must be accepted. A second hard case keeps the strobe low for longer than the whole lockout. This checks that the end of the lockout does not count as a fresh edge. Pulses of exactly `QUAL_CYCLES`−1 and `QUAL_CYCLES` samples probe the qualification boundary from both sides.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_COUNT = 2'd1,
        QS_HOLD  = 2'd2
    } qual_state_e;

endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int   W       = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {2{RST_VAL}};
            else        stage_q <= {stage_q[0], d[i]};
        end
        assign q[i] = stage_q[1];
    end
endmodule

// File: rtl/chsel_qual.sv
module chsel_qual
    import chsel_pkg::*;
#(
    parameter int CODE_W      = 7,
    parameter int NUM_CH      = 120,
    parameter int QUAL_CYCLES = 28,
    parameter int LOCK_CYCLES = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_s,
    input  logic [CODE_W-1:0] code_s,
    output logic              accept_o,
    output logic              rd_en_o,
    output logic [CODE_W-1:0] rd_addr_o,
    output logic              lock_busy_o
);
    localparam int QCNT_W = $clog2(QUAL_CYCLES + 1);
    localparam int LCNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CODE_W-1:0] LAST_CH  = CODE_W'(NUM_CH - 1);
    localparam logic [QCNT_W-1:0] QUAL_END = QCNT_W'(QUAL_CYCLES - 1);
    localparam logic [LCNT_W-1:0] LOCK_LD  = LCNT_W'(LOCK_CYCLES);

    typedef struct packed {
        qual_state_e       st;
        logic [QCNT_W-1:0] cnt;
        logic [LCNT_W-1:0] lock;
        logic              prev;
    } qual_reg_t;

    qual_reg_t d_s, q_s;
    logic      accept_d, rd_en_d;

    always_comb begin
        d_s      = q_s;
        accept_d = 1'b0;
        rd_en_d  = 1'b0;
        d_s.prev = set_s;
        if (q_s.lock != '0) d_s.lock = q_s.lock - 1'b1;
        unique case (q_s.st)
            QS_IDLE: begin
                if (!set_s && q_s.prev && (q_s.lock == '0)) begin
                    d_s.st  = QS_COUNT;
                    d_s.cnt = QCNT_W'(1);
                end
            end
            QS_COUNT: begin
                if (set_s) begin
                    d_s.st = QS_IDLE;
                end else if (q_s.cnt == QUAL_END) begin
                    accept_d = 1'b1;
                    d_s.st   = QS_HOLD;
                    if (code_s <= LAST_CH) begin
                        rd_en_d  = 1'b1;
                        d_s.lock = LOCK_LD;
                    end
                end else begin
                    d_s.cnt = q_s.cnt + 1'b1;
                end
            end
            QS_HOLD: begin
                if (set_s) d_s.st = QS_IDLE;
            end
            default: d_s.st = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_s.st   <= QS_IDLE;
            q_s.cnt  <= '0;
            q_s.lock <= '0;
            q_s.prev <= 1'b1;
        end else begin
            q_s <= d_s;
        end
    end

    assign accept_o    = accept_d;
    assign rd_en_o     = rd_en_d;
    assign rd_addr_o   = code_s;
    assign lock_busy_o = (q_s.lock != '0);
endmodule

// File: rtl/chsel_table.sv
module chsel_table #(
    parameter int CODE_W = 7,
    parameter int NUM_CH = 120,
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [CODE_W-1:0] waddr,
    input  logic [FREQ_W-1:0] wdata,
    input  logic              re,
    input  logic [CODE_W-1:0] raddr,
    output logic [FREQ_W-1:0] rdata
);
    localparam logic [CODE_W-1:0] LAST_CH = CODE_W'(NUM_CH - 1);

    logic [FREQ_W-1:0] mem [NUM_CH];
    logic [FREQ_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we && (waddr <= LAST_CH)) mem[waddr] <= wdata;
        if (re && (raddr <= LAST_CH)) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/chan_strobe_sel.sv
module chan_strobe_sel #(
    parameter int CODE_W      = 7,
    parameter int NUM_CH      = 120,
    parameter int FREQ_W      = 32,
    parameter int QUAL_CYCLES = 28,
    parameter int LOCK_CYCLES = 20000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              tbl_we_i,
    input  logic [CODE_W-1:0] tbl_waddr_i,
    input  logic [FREQ_W-1:0] tbl_wdata_i,
    output logic [FREQ_W-1:0] freq_o,
    output logic              freq_vld_o
);
    localparam int SYNC_W = CODE_W + 1;

    logic [SYNC_W-1:0] sync_out;
    logic              set_s;
    logic [CODE_W-1:0] code_s;
    logic              accept, rd_en, lock_busy;
    logic [CODE_W-1:0] rd_addr;
    logic [FREQ_W-1:0] rd_data;

    chsel_sync #(.W(SYNC_W), .RST_VAL(1'b1)) u_sync (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .d     ({set_ni, code_i}),
        .q     (sync_out)
    );
    assign set_s  = sync_out[SYNC_W-1];
    assign code_s = sync_out[CODE_W-1:0];

    chsel_qual #(
        .CODE_W(CODE_W), .NUM_CH(NUM_CH),
        .QUAL_CYCLES(QUAL_CYCLES), .LOCK_CYCLES(LOCK_CYCLES)
    ) u_qual (
        .clk         (clk_i),
        .rst_n       (rst_ni),
        .set_s       (set_s),
        .code_s      (code_s),
        .accept_o    (accept),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .lock_busy_o (lock_busy)
    );

    chsel_table #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .FREQ_W(FREQ_W)) u_tbl (
        .clk   (clk_i),
        .we    (tbl_we_i),
        .waddr (tbl_waddr_i),
        .wdata (tbl_wdata_i),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    typedef struct packed {
        logic              pend;
        logic              vld;
        logic [FREQ_W-1:0] freq;
    } out_reg_t;

    out_reg_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.pend = rd_en;
        out_d.vld  = out_q.pend;
        if (out_q.pend) out_d.freq = rd_data;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign freq_o     = out_q.freq;
    assign freq_vld_o = out_q.vld;
endmodule

// File: rtl/chsel_chk.sv
module chsel_chk #(
    parameter int CODE_W = 7,
    parameter int NUM_CH = 120,
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_s,
    input logic              accept,
    input logic              rd_en,
    input logic [CODE_W-1:0] rd_addr,
    input logic              lock_busy,
    input logic [FREQ_W-1:0] freq,
    input logic              vld
);
    localparam logic [CODE_W-1:0] LAST_CH = CODE_W'(NUM_CH - 1);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    assert_freq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> $stable(freq));

    assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr <= LAST_CH));

    assert_qual_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (!set_s && !$past(set_s)));

    assert_no_capture_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !lock_busy);

    assert_read_to_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 vld);
endmodule

bind chan_strobe_sel chsel_chk #(
    .CODE_W(CODE_W), .NUM_CH(NUM_CH), .FREQ_W(FREQ_W)
) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .set_s     (set_s),
    .accept    (accept),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .lock_busy (lock_busy),
    .freq      (freq_o),
    .vld       (freq_vld_o)
);

// File: tb/sim_chan_strobe_sel.sv
module sim_chan_strobe_sel;
    localparam int CODE_W = 7;
    localparam int NUM_CH = 120;
    localparam int FREQ_W = 32;
    localparam int QUAL   = 28;
    localparam int LOCK   = 500;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              set_n = 1'b1;
    logic [CODE_W-1:0] code = '1;
    logic              we = 1'b0;
    logic [CODE_W-1:0] waddr = '0;
    logic [FREQ_W-1:0] wdata = '0;
    logic [FREQ_W-1:0] freq;
    logic              vld;

    chan_strobe_sel #(
        .CODE_W(CODE_W), .NUM_CH(NUM_CH), .FREQ_W(FREQ_W),
        .QUAL_CYCLES(QUAL), .LOCK_CYCLES(LOCK)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .set_ni(set_n), .code_i(code),
        .tbl_we_i(we), .tbl_waddr_i(waddr), .tbl_wdata_i(wdata),
        .freq_o(freq), .freq_vld_o(vld)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [FREQ_W-1:0] f;
        int                t0;
    } exp_t;

    exp_t              sb_q[$];
    logic [FREQ_W-1:0] model [NUM_CH];
    int                cyc = 0;
    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pop and compare (R2 value, R9 latency)
    always @(negedge clk) begin
        if (rst_n && vld) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected valid pulse", longint'(freq), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(freq == e.f, "R2 frequency word", longint'(freq), longint'(e.f));
                chk((cyc - e.t0) == QUAL + 3, "R9 latency", cyc - e.t0, QUAL + 3);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tbl_write(input int a, input logic [FREQ_W-1:0] v);
        @(negedge clk);
        we = 1'b1; waddr = CODE_W'(a); wdata = v;
        model[a] = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    // driver: one strobe; pushes an expectation when a result is due
    task automatic strobe(input int c, input int low, input bit expect_out);
        @(negedge clk);
        code = CODE_W'(c);
        set_n = 1'b0;
        if (expect_out) begin
            exp_t e;
            e.f  = model[c];
            e.t0 = cyc;
            sb_q.push_back(e);
        end
        wait_cyc(low);
        set_n = 1'b1;
    endtask

    task automatic drained(input string tag);
        wait_cyc(QUAL + 8);
        chk(sb_q.size() == 0, tag, sb_q.size(), 0);
    endtask

    initial begin
        wait_cyc(5);
        chk(vld == 1'b0, "R1 valid in reset", vld, 0);
        chk(freq == '0, "R1 freq in reset", longint'(freq), 0);
        rst_n = 1'b1;
        wait_cyc(10);
        chk(vld == 1'b0 && freq == '0, "R1 after reset", longint'(freq), 0);

        for (int i = 0; i < NUM_CH; i++)
            tbl_write(i, FREQ_W'(1_000_000 + i * 1_000_003));

        // R2: several channels
        strobe(0, QUAL + 10, 1'b1);    drained("R2 ch0 delivered");
        wait_cyc(LOCK);
        strobe(119, QUAL + 10, 1'b1);  drained("R2 ch119 delivered");
        wait_cyc(LOCK);
        strobe(85, QUAL + 10, 1'b1);   drained("R2 ch85 delivered");
        wait_cyc(LOCK);

        // R3: one sample short, then exactly QUAL with no lockout in between
        strobe(10, QUAL - 1, 1'b0);
        drained("R3 short pulse no output");
        chk(freq == model[85], "R3 freq unchanged", longint'(freq), longint'(model[85]));
        strobe(10, QUAL, 1'b1);        drained("R3 exact width accepted");
        wait_cyc(LOCK);

        // R4: out-of-range codes, then immediate valid strobe
        strobe(120, QUAL + 10, 1'b0);  drained("R4 code 120 ignored");
        strobe(127, QUAL + 10, 1'b0);  drained("R4 code 127 ignored");
        chk(freq == model[10], "R4 freq unchanged", longint'(freq), longint'(model[10]));
        strobe(3, QUAL + 10, 1'b1);    drained("R4 no lockout after invalid");

        // R5: edge inside lockout dropped, edge after it accepted
        wait_cyc(50);
        strobe(4, QUAL + 20, 1'b0);    drained("R5 locked edge ignored");
        chk(freq == model[3], "R5 freq unchanged", longint'(freq), longint'(model[3]));
        wait_cyc(LOCK);
        strobe(4, QUAL + 10, 1'b1);    drained("R5 edge after lockout");
        wait_cyc(LOCK);

        // R6: held low beyond lockout, single capture
        strobe(6, 2 * LOCK + 100, 1'b1);
        drained("R6 single capture while held");
        wait_cyc(LOCK);

        // R7: rewrite an entry, then select it
        tbl_write(6, 32'd130_000_000);
        strobe(6, QUAL + 10, 1'b1);    drained("R7 rewritten entry");
        chk(freq == 32'd130_000_000, "R7 freq held R8", longint'(freq), 130_000_000);
        wait_cyc(20);
        chk(freq == 32'd130_000_000 && !vld, "R8 hold between pulses",
            longint'(freq), 130_000_000);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule